// File: doc/BRIEF.md
# Password-Gated Array Segment Protection Unit

This unit is the access-control stage of a serial memory controller with a 512-location byte array. It keeps a movable boundary pointer that splits the array into a lower, read-only segment and an upper segment. While no access code is stored, the upper segment is fully open. Once a code of one to eight bytes is stored, the unit is in secure mode. In that mode the upper segment can be read or written only after the matching code has been presented.

The opcode decoder upstream sends one strobe per decoded instruction: store a code, present a code byte by byte, drop access, load the pointer, arm a one-shot override, or read the pointer back. Every decoded read, program or erase request goes through the unit together with its target address. One cycle later the unit answers with exactly one pulse, either grant or deny. The override lets exactly one program or erase land in the lower segment. After that one operation the lower segment is locked again. The serial shifter, the cell timing and the nonvolatile storage itself are outside the unit; stored state is held in plain registers.

Top module: `seg_guard`

## Requirements
- R1: After reset no code is stored (unprotected mode), the pointer is 0, access is not granted, the override is disarmed and all outputs are low.
- R2: In unprotected mode a request at an address greater than or equal to the pointer is granted for every kind. Below the pointer (unsigned compare), a read is granted and a program or erase is denied unless the override is armed.
- R3: A code-store strobe with length L in 1..8 stores L bytes. Byte k is taken from key value bits [8k+7:8k], and the first presented byte is compared with byte 0. L = 0 returns the unit to unprotected mode, and L above 8 is ignored. In secure mode the strobe is ignored unless access is granted. A strobe that takes effect clears the granted flag.
- R4: In secure mode a request at or above the pointer is denied for every kind unless access is granted. Below the pointer, reads are granted and program or erase needs the override, whether or not access is granted.
- R5: A code presentation (begin strobe, byte strobes, end strobe) grants access only when the number of bytes equals the stored length and every byte matches in order. Any mismatch, a missing byte or an extra byte clears the granted flag at the end strobe.
- R6: Granted access lasts until reset, a lock strobe, a code-store strobe that takes effect, or a failed presentation.
- R7: A pointer-write strobe loads the given address when the unit is unprotected or access is granted, and is ignored otherwise. The pointer changes in no other way.
- R8: An override strobe arms the override when the unit is unprotected or access is granted, and is ignored otherwise. Exactly one granted program or erase below the pointer consumes it. Reads, and requests at or above the pointer, leave it armed.
- R9: A pointer-read strobe makes the readout-valid output high on the next cycle, with the pointer value current at the strobe.
- R10: For each request, exactly one of grant or deny pulses one cycle later, and neither pulses without a request. Kind encoding: 0 read, 1 program, 2 erase, 3 reserved and always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_set_i | input | 1 | Store-code strobe |
| key_len_i | input | 4 | Code length in bytes (0 clears protection) |
| key_val_i | input | 64 | Code bytes, byte k at bits [8k+7:8k] |
| unlock_begin_i | input | 1 | Starts a code presentation |
| unlock_byte_valid_i | input | 1 | One presented code byte |
| unlock_byte_i | input | 8 | Presented code byte |
| unlock_end_i | input | 1 | Ends a presentation and evaluates it |
| lock_i | input | 1 | Drops granted access |
| ptr_wr_i | input | 1 | Pointer-write strobe |
| ptr_addr_i | input | 9 | New pointer value |
| ovr_i | input | 1 | Arms the one-shot override |
| ptr_rd_i | input | 1 | Pointer-read strobe |
| req_valid_i | input | 1 | Access request present |
| req_kind_i | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_addr_i | input | 9 | Request address |
| req_grant_o | output | 1 | Request allowed (one cycle after request) |
| req_deny_o | output | 1 | Request refused (one cycle after request) |
| ptr_rd_valid_o | output | 1 | Pointer readout valid |
| ptr_rd_data_o | output | 9 | Pointer readout value |

## Verification
Requests go to addresses on both sides of the pointer and exactly at it, with every kind including the reserved code, in both modes. This separates the read-only rule from the fully-open and password-only rules, and catches an off-by-one boundary compare. Code presentations that are correct, have one wrong byte, are one byte short or are one byte long separate exact matching from prefix matching or count-blind matching. Override sequences mixed with reads and upper-segment writes, and pointer or code strobes sent without access, show whether the one-shot is consumed only by the right operation and whether protected state ignores unauthorised strobes.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_PROG  = 2'd1,
        KIND_ERASE = 2'd2,
        KIND_RSVD  = 2'd3
    } req_kind_e;

endpackage

// File: rtl/key_store.sv
module key_store #(
    parameter int unsigned KEY_BYTES = 8,
    parameter int unsigned LEN_W     = $clog2(KEY_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_i,
    input  logic [LEN_W-1:0]       set_len_i,
    input  logic [KEY_BYTES*8-1:0] set_val_i,
    input  logic                   granted_i,
    output logic [KEY_BYTES*8-1:0] key_o,
    output logic [LEN_W-1:0]       len_o,
    output logic                   secure_o,
    output logic                   set_ok_o
);

    typedef struct packed {
        logic [KEY_BYTES*8-1:0] key;
        logic [LEN_W-1:0]       len;
    } ks_state_t;

    ks_state_t st_d, st_q;
    logic      set_ok;

    always_comb begin
        st_d   = st_q;
        set_ok = 1'b0;
        if (set_i && (set_len_i <= LEN_W'(KEY_BYTES)) &&
            ((st_q.len == '0) || granted_i)) begin
            set_ok   = 1'b1;
            st_d.len = set_len_i;
            st_d.key = (set_len_i == '0) ? '0 : set_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_o    = st_q.key;
    assign len_o    = st_q.len;
    assign secure_o = (st_q.len != '0);
    assign set_ok_o = set_ok;

endmodule

// File: rtl/code_matcher.sv
module code_matcher #(
    parameter int unsigned KEY_BYTES = 8,
    parameter int unsigned LEN_W     = $clog2(KEY_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [KEY_BYTES*8-1:0] key_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic                   begin_i,
    input  logic                   byte_valid_i,
    input  logic [7:0]             byte_i,
    input  logic                   end_i,
    input  logic                   lock_i,
    input  logic                   clear_i,
    output logic                   granted_o
);

    typedef struct packed {
        logic [LEN_W-1:0] idx;
        logic             bad;
        logic             granted;
    } cm_state_t;

    cm_state_t  st_d, st_q;
    logic [7:0] cur_byte;
    logic       in_range;

    always_comb begin
        cur_byte = '0;
        for (int k = 0; k < KEY_BYTES; k++) begin
            if (st_q.idx == LEN_W'(k)) cur_byte = key_i[k*8 +: 8];
        end
    end

    assign in_range = (st_q.idx < len_i);

    always_comb begin
        st_d = st_q;
        if (begin_i) begin
            st_d.idx = '0;
            st_d.bad = 1'b0;
        end else if (byte_valid_i) begin
            if (in_range) begin
                if (byte_i != cur_byte) st_d.bad = 1'b1;
                st_d.idx = st_q.idx + 1'b1;
            end else begin
                st_d.bad = 1'b1;
            end
        end else if (end_i) begin
            st_d.granted = !st_q.bad && (st_q.idx == len_i) && (len_i != '0);
        end
        if (lock_i || clear_i) st_d.granted = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign granted_o = st_q.granted;

endmodule

// File: rtl/seg_pointer.sv
module seg_pointer #(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ovr_i,
    input  logic              allow_i,
    input  logic              consume_i,
    input  logic              rd_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              ovr_armed_o,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              armed;
        logic              rd_v;
        logic [ADDR_W-1:0] rd_d;
    } sp_state_t;

    sp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rd_v = rd_i;
        st_d.rd_d = rd_i ? st_q.ptr : '0;
        if (wr_i && allow_i) st_d.ptr = addr_i;
        if (consume_i)       st_d.armed = 1'b0;
        if (ovr_i && allow_i) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o       = st_q.ptr;
    assign ovr_armed_o = st_q.armed;
    assign rd_valid_o  = st_q.rd_v;
    assign rd_data_o   = st_q.rd_d;

endmodule

// File: rtl/access_arbiter.sv
module access_arbiter
    import seg_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              ovr_armed_i,
    input  logic              allow_i,
    output logic              consume_o,
    output logic              grant_o,
    output logic              deny_o
);

    typedef struct packed {
        logic grant;
        logic deny;
    } aa_state_t;

    aa_state_t st_d, st_q;
    req_kind_e kind;
    logic      below;
    logic      is_write;
    logic      ok;

    always_comb begin
        kind     = req_kind_e'(req_kind_i);
        below    = (req_addr_i < ptr_i);
        is_write = (kind == KIND_PROG) || (kind == KIND_ERASE);
        if (kind == KIND_RSVD)  ok = 1'b0;
        else if (below)         ok = !is_write || ovr_armed_i;
        else                    ok = allow_i;
        consume_o  = req_valid_i && below && is_write && ovr_armed_i;
        st_d.grant = req_valid_i && ok;
        st_d.deny  = req_valid_i && !ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o = st_q.grant;
    assign deny_o  = st_q.deny;

endmodule

// File: rtl/seg_guard.sv
module seg_guard #(
    parameter  int unsigned KEY_BYTES = 8,
    parameter  int unsigned ADDR_W    = 9,
    localparam int unsigned LEN_W     = $clog2(KEY_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   key_set_i,
    input  logic [LEN_W-1:0]       key_len_i,
    input  logic [KEY_BYTES*8-1:0] key_val_i,
    input  logic                   unlock_begin_i,
    input  logic                   unlock_byte_valid_i,
    input  logic [7:0]             unlock_byte_i,
    input  logic                   unlock_end_i,
    input  logic                   lock_i,
    input  logic                   ptr_wr_i,
    input  logic [ADDR_W-1:0]      ptr_addr_i,
    input  logic                   ovr_i,
    input  logic                   ptr_rd_i,
    input  logic                   req_valid_i,
    input  logic [1:0]             req_kind_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    output logic                   req_grant_o,
    output logic                   req_deny_o,
    output logic                   ptr_rd_valid_o,
    output logic [ADDR_W-1:0]      ptr_rd_data_o
);

    logic [KEY_BYTES*8-1:0] key_w;
    logic [LEN_W-1:0]       len_w;
    logic                   secure_w;
    logic                   set_ok_w;
    logic                   granted_w;
    logic                   allow_w;
    logic [ADDR_W-1:0]      ptr_w;
    logic                   ovr_armed_w;
    logic                   consume_w;

    assign allow_w = !secure_w || granted_w;

    key_store #(.KEY_BYTES(KEY_BYTES), .LEN_W(LEN_W)) key_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (key_set_i),
        .set_len_i (key_len_i),
        .set_val_i (key_val_i),
        .granted_i (granted_w),
        .key_o     (key_w),
        .len_o     (len_w),
        .secure_o  (secure_w),
        .set_ok_o  (set_ok_w)
    );

    code_matcher #(.KEY_BYTES(KEY_BYTES), .LEN_W(LEN_W)) match_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_i        (key_w),
        .len_i        (len_w),
        .begin_i      (unlock_begin_i),
        .byte_valid_i (unlock_byte_valid_i),
        .byte_i       (unlock_byte_i),
        .end_i        (unlock_end_i),
        .lock_i       (lock_i),
        .clear_i      (set_ok_w),
        .granted_o    (granted_w)
    );

    seg_pointer #(.ADDR_W(ADDR_W)) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (ptr_wr_i),
        .addr_i      (ptr_addr_i),
        .ovr_i       (ovr_i),
        .allow_i     (allow_w),
        .consume_i   (consume_w),
        .rd_i        (ptr_rd_i),
        .ptr_o       (ptr_w),
        .ovr_armed_o (ovr_armed_w),
        .rd_valid_o  (ptr_rd_valid_o),
        .rd_data_o   (ptr_rd_data_o)
    );

    access_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_kind_i  (req_kind_i),
        .req_addr_i  (req_addr_i),
        .ptr_i       (ptr_w),
        .ovr_armed_i (ovr_armed_w),
        .allow_i     (allow_w),
        .consume_o   (consume_w),
        .grant_o     (req_grant_o),
        .deny_o      (req_deny_o)
    );

endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [1:0]        req_kind_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              ovr_i,
    input logic              ptr_wr_i,
    input logic              ptr_rd_i,
    input logic [ADDR_W-1:0] ptr_val,
    input logic              ovr_armed,
    input logic              secure,
    input logic              granted,
    input logic              req_grant_o,
    input logic              req_deny_o,
    input logic              ptr_rd_valid_o,
    input logic [ADDR_W-1:0] ptr_rd_data_o
);

    logic wr_kind;
    assign wr_kind = (req_kind_i == 2'd1) || (req_kind_i == 2'd2);

    a_r2_read_below_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i == 2'd0 && req_addr_i < ptr_val) |=> req_grant_o);

    a_r2_write_below_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && wr_kind && req_addr_i < ptr_val && !ovr_armed) |=> req_deny_o);

    a_r2_unprot_upper_open: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !secure && req_kind_i != 2'd3 && req_addr_i >= ptr_val) |=> req_grant_o);

    a_r4_secure_upper_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && secure && !granted && req_addr_i >= ptr_val) |=> req_deny_o);

    a_r7_ptr_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_wr_i |=> $stable(ptr_val));

    a_r8_override_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && wr_kind && req_addr_i < ptr_val && ovr_armed && !ovr_i) |=> !ovr_armed);

    a_r9_ptr_readout: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd_i |=> (ptr_rd_valid_o && ptr_rd_data_o == $past(ptr_val)));

    a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (req_grant_o ^ req_deny_o));

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant_o || req_deny_o) |-> $past(req_valid_i));

endmodule

bind seg_guard seg_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_kind_i     (req_kind_i),
    .req_addr_i     (req_addr_i),
    .ovr_i          (ovr_i),
    .ptr_wr_i       (ptr_wr_i),
    .ptr_rd_i       (ptr_rd_i),
    .ptr_val        (ptr_w),
    .ovr_armed      (ovr_armed_w),
    .secure         (secure_w),
    .granted        (granted_w),
    .req_grant_o    (req_grant_o),
    .req_deny_o     (req_deny_o),
    .ptr_rd_valid_o (ptr_rd_valid_o),
    .ptr_rd_data_o  (ptr_rd_data_o)
);

// File: tb/seg_guard_tb_top.sv
`timescale 1ns/1ps
module seg_guard_tb_top;

    localparam int KB = 8;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_set_i = 1'b0;
    logic [3:0]    key_len_i = '0;
    logic [KB*8-1:0] key_val_i = '0;
    logic          unlock_begin_i = 1'b0;
    logic          unlock_byte_valid_i = 1'b0;
    logic [7:0]    unlock_byte_i = '0;
    logic          unlock_end_i = 1'b0;
    logic          lock_i = 1'b0;
    logic          ptr_wr_i = 1'b0;
    logic [AW-1:0] ptr_addr_i = '0;
    logic          ovr_i = 1'b0;
    logic          ptr_rd_i = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [1:0]    req_kind_i = '0;
    logic [AW-1:0] req_addr_i = '0;
    logic          req_grant_o, req_deny_o, ptr_rd_valid_o;
    logic [AW-1:0] ptr_rd_data_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seg_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .key_set_i(key_set_i), .key_len_i(key_len_i), .key_val_i(key_val_i),
        .unlock_begin_i(unlock_begin_i), .unlock_byte_valid_i(unlock_byte_valid_i),
        .unlock_byte_i(unlock_byte_i), .unlock_end_i(unlock_end_i), .lock_i(lock_i),
        .ptr_wr_i(ptr_wr_i), .ptr_addr_i(ptr_addr_i), .ovr_i(ovr_i), .ptr_rd_i(ptr_rd_i),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_addr_i(req_addr_i),
        .req_grant_o(req_grant_o), .req_deny_o(req_deny_o),
        .ptr_rd_valid_o(ptr_rd_valid_o), .ptr_rd_data_o(ptr_rd_data_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // request: drive one cycle, answer appears after the next edge
    task automatic req(input logic [1:0] kind, input int addr, input bit exp_ok, input string tag);
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = kind; req_addr_i = AW'(addr);
        @(negedge clk);
        req_valid_i = 1'b0;
        check(tag, {req_grant_o, req_deny_o}, exp_ok ? 2 : 1);
    endtask

    task automatic ptr_write(input int addr);
        @(negedge clk); ptr_wr_i = 1'b1; ptr_addr_i = AW'(addr);
        @(negedge clk); ptr_wr_i = 1'b0;
    endtask

    task automatic ptr_read(input int exp, input string tag);
        @(negedge clk); ptr_rd_i = 1'b1;
        @(negedge clk); ptr_rd_i = 1'b0;
        check(tag, {ptr_rd_valid_o, ptr_rd_data_o}, (1 << AW) | exp);
    endtask

    task automatic arm_override();
        @(negedge clk); ovr_i = 1'b1;
        @(negedge clk); ovr_i = 1'b0;
    endtask

    task automatic set_key(input int len, input logic [KB*8-1:0] val);
        @(negedge clk); key_set_i = 1'b1; key_len_i = 4'(len); key_val_i = val;
        @(negedge clk); key_set_i = 1'b0;
    endtask

    task automatic do_lock();
        @(negedge clk); lock_i = 1'b1;
        @(negedge clk); lock_i = 1'b0;
    endtask

    task automatic present(input logic [7:0] b [], input int n);
        @(negedge clk); unlock_begin_i = 1'b1;
        @(negedge clk); unlock_begin_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            unlock_byte_valid_i = 1'b1; unlock_byte_i = b[i];
            @(negedge clk);
        end
        unlock_byte_valid_i = 1'b0;
        unlock_end_i = 1'b1;
        @(negedge clk); unlock_end_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 grant low after reset", req_grant_o, 0);
        check("R1 deny low after reset", req_deny_o, 0);
        check("R1 readout low after reset", ptr_rd_valid_o, 0);
        ptr_read(0, "R1 pointer zero after reset");
        req(2'd1, 511, 1, "R1 R2 unprotected program top address");
        req(2'd2, 0, 1, "R1 R2 unprotected erase address 0");
    endtask

    task automatic t_unprot();
        ptr_write(100);
        ptr_read(100, "R7 R9 pointer loaded unprotected");
        req(2'd0, 99, 1, "R2 read below pointer");
        req(2'd1, 99, 0, "R2 program below pointer denied");
        req(2'd2, 0, 0, "R2 erase at 0 below pointer denied");
        req(2'd1, 100, 1, "R2 program at pointer granted");
        req(2'd3, 100, 0, "R10 reserved kind denied");
    endtask

    task automatic t_override();
        arm_override();
        req(2'd1, 50, 1, "R8 override program below");
        req(2'd1, 50, 0, "R8 second program below denied");
        arm_override();
        req(2'd0, 50, 1, "R8 read does not consume");
        req(2'd2, 200, 1, "R8 upper erase does not consume");
        req(2'd2, 99, 1, "R8 override erase below");
        req(2'd2, 99, 0, "R8 override consumed");
    endtask

    task automatic t_secure();
        set_key(9, 64'h0);
        req(2'd1, 200, 1, "R3 length 9 ignored");
        set_key(3, 64'h0000_0000_0033_2211);
        req(2'd0, 200, 0, "R4 secure read upper denied");
        req(2'd1, 100, 0, "R4 secure program at pointer denied");
        req(2'd0, 50, 1, "R4 secure read below granted");
        ptr_write(10);
        ptr_read(100, "R7 pointer write ignored without access");
        arm_override();
        req(2'd1, 50, 0, "R8 override ignored without access");
        set_key(0, 64'h0);
        req(2'd0, 200, 0, "R3 code store ignored without access");
    endtask

    task automatic t_unlock();
        logic [7:0] good [] = '{8'h11, 8'h22, 8'h33};
        logic [7:0] wrong [] = '{8'h11, 8'h22, 8'h34};
        logic [7:0] shrt [] = '{8'h11, 8'h22};
        logic [7:0] lng [] = '{8'h11, 8'h22, 8'h33, 8'h44};
        logic [7:0] swp [] = '{8'h33, 8'h22, 8'h11};
        present(wrong, 3);
        req(2'd0, 200, 0, "R5 wrong last byte denied");
        present(shrt, 2);
        req(2'd0, 200, 0, "R5 short code denied");
        present(lng, 4);
        req(2'd0, 200, 0, "R5 long code denied");
        present(swp, 3);
        req(2'd0, 200, 0, "R5 reversed byte order denied");
        present(good, 3);
        req(2'd0, 200, 1, "R5 correct code read upper");
        req(2'd1, 300, 1, "R5 correct code program upper");
        req(2'd1, 99, 0, "R4 below stays read-only with access");
        repeat (20) @(negedge clk);
        req(2'd2, 100, 1, "R6 access persists");
        ptr_write(150);
        ptr_read(150, "R7 pointer write with access");
        req(2'd1, 120, 0, "R7 new pointer protects below");
        present(wrong, 3);
        req(2'd0, 200, 0, "R5 failed attempt clears access");
        present(good, 3);
        do_lock();
        req(2'd0, 200, 0, "R6 lock drops access");
        present(good, 3);
        set_key(1, 64'h5A);
        req(2'd0, 200, 0, "R3 code store clears access");
    endtask

    task automatic t_rekey();
        logic [7:0] one [] = '{8'h5A};
        present(one, 1);
        req(2'd0, 200, 1, "R3 one-byte code accepted");
        set_key(0, 64'h0);
        req(2'd1, 400, 1, "R3 zero length returns unprotected");
    endtask

    task automatic t_rst_again();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        ptr_read(0, "R1 reset clears pointer");
        req(2'd1, 5, 1, "R1 reset unprotected open");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unprot();
        t_override();
        t_secure();
        t_unlock();
        t_rekey();
        t_rst_again();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule